// File: doc/BRIEF.md
# Asymmetric Dual-Port RAM with Parity Lanes

This block is a true dual-port synchronous RAM. Both ports share one array that holds 16,384 data bits and 2,048 parity bits, arranged as 512 words of 32 data bits plus 4 parity bits. Each port has its own clock, enable, write enable, synchronous output set/reset, address, write data, write parity, read data and read parity. Each port is given its own width at build time. The choices are 1, 2, 4, 9, 18 or 36 bits, so data written through one shape can be read back through another. This makes the RAM usable as a bus-width converter between two clock domains or two datapaths.

In the 9-, 18- and 36-bit shapes a port word is one parity bit for each data byte. The parity bits are stored and read back exactly like data bits. The block never generates or checks parity itself. Ports in the 1-, 2- and 4-bit shapes see only the 32-bit data part of each word. Writes from such a port never touch the parity bits.

Top module: `asym_dpram`

## Requirements
- R1: Each port's width parameter is one of 1, 2, 4, 9, 18 or 36, and any pairing of the two ports is legal. A port address maps to storage word `addr >> L` and lane `addr mod 2^L`, where L is 5, 4, 3, 2, 1 or 0 for those widths in that order. Lane n of a word holds data bits [n*D +: D] and parity bits [n*P +: P]. D is 1, 2, 4, 8, 16 or 32 and P is 0, 0, 0, 1, 2 or 4. Address bits above the ones a shape needs are ignored. Every write changes exactly D+P stored bits.
- R2: In the 9-, 18- and 36-bit shapes, a lane's data is on `rdata[D-1:0]` / `wdata[D-1:0]` and its parity is on `rpar[P-1:0]` / `wpar[P-1:0]`. Parity bit k belongs to data byte k of the lane. Parity round-trips unchanged.
- R3: In the 1-, 2- and 4-bit shapes, `wpar` is ignored and `rpar` reads 0. Writes from such a port leave every stored parity bit unchanged.
- R4: Bits of `rdata` at and above D, and bits of `rpar` at and above P, read 0. The matching bits of `wdata` and `wpar` are ignored.
- R5: While a port's enable is low, that port performs no write and its output registers hold their value.
- R6: With the enable high, the read result appears on the outputs only after the rising clock edge that samples the address. An address change between edges does not alter the outputs.
- R7: A write with the enable high and set/reset low also loads that port's outputs with the lane just written (write-first).
- R8: With the enable high and set/reset high, the port's outputs load its init parameter, masked to the port shape per R4, instead of read data. Set/reset does not alter the array. A write issued in the same cycle is still stored.
- R9: Data and parity written through one port are returned by the other port's next read, for any pairing of shapes.
- R10: Writes from both ports in the same cycle to non-overlapping bits both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_srst | input | 1 | Port A synchronous output set/reset |
| a_addr | input | 14 | Port A address, low bits used per shape |
| a_wdata | input | 32 | Port A write data, low D bits used |
| a_wpar | input | 4 | Port A write parity, low P bits used |
| a_rdata | output | 32 | Port A registered read data |
| a_rpar | output | 4 | Port A registered read parity |
| b_clk | input | 1 | Port B clock |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_srst | input | 1 | Port B synchronous output set/reset |
| b_addr | input | 14 | Port B address, low bits used per shape |
| b_wdata | input | 32 | Port B write data, low D bits used |
| b_wpar | input | 4 | Port B write parity, low P bits used |
| b_rdata | output | 32 | Port B registered read data |
| b_rpar | output | 4 | Port B registered read parity |

## Verification
Six instances pair a 36-bit port A with each of the six port B shapes. A full sweep of word-unique patterns written wide and read back through every narrow address tells correct lane order and byte-to-parity pairing apart from swapped or shifted lanes. A second pass writes through each narrow shape with the parity inputs held at all ones and reads back wide. This separates data that lands in the right lane, with stored parity untouched, from writes that spill into neighbour lanes or parity. Targeted patterns for an idle port, set/reset with and without a write, a mid-cycle address change and concurrent writes on both ports separate hold, init, registered-read and two-writer behaviour.

// File: rtl/adpr_pkg.sv
package adpr_pkg;

  localparam int unsigned WORD_DW    = 32;
  localparam int unsigned WORD_PW    = 4;
  localparam int unsigned LANE_LOG2W = 5;

  typedef struct packed {
    logic [WORD_PW-1:0] par;
    logic [WORD_DW-1:0] dat;
  } cell_t;

  // log2 of the number of lanes per storage word for a port width
  function automatic int unsigned lane_log2(input int unsigned w);
    case (w)
      1:       return 5;
      2:       return 4;
      4:       return 3;
      9:       return 2;
      18:      return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned data_bits(input int unsigned w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int unsigned par_bits(input int unsigned w);
    return (w >= 9) ? w / 9 : 0;
  endfunction

  function automatic bit legal_width(input int unsigned w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
  endfunction

  // bits of a storage word owned by a lane
  function automatic cell_t lane_mask(input int unsigned w, input int unsigned lane);
    cell_t       m;
    logic [63:0] dl;
    logic [7:0]  pl;
    dl    = (64'd1 << data_bits(w)) - 64'd1;
    pl    = (8'd1 << par_bits(w)) - 8'd1;
    m.dat = dl[WORD_DW-1:0] << (lane * data_bits(w));
    m.par = pl[WORD_PW-1:0] << (lane * par_bits(w));
    return m;
  endfunction

  // move a lane value from bit 0 up to its lane position
  function automatic cell_t lane_put(input int unsigned w, input int unsigned lane, input cell_t low);
    cell_t r;
    r.dat = low.dat << (lane * data_bits(w));
    r.par = low.par << (lane * par_bits(w));
    return r;
  endfunction

  // bring a lane down to bit 0 and clear everything above it
  function automatic cell_t lane_take(input int unsigned w, input int unsigned lane, input cell_t word);
    cell_t r;
    r.dat = word.dat >> (lane * data_bits(w));
    r.par = word.par >> (lane * par_bits(w));
    return r & lane_mask(w, 0);
  endfunction

endpackage

// File: rtl/adpr_bank.sv
module adpr_bank
  import adpr_pkg::*;
#(
  parameter  int unsigned DEPTH = 512,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  cell_t            wr_mask,
  input  cell_t            wr_val,
  input  logic [IDX_W-1:0] rd_idx0,
  input  logic [IDX_W-1:0] rd_idx1,
  output cell_t            rd_q0,
  output cell_t            rd_q1
);

  cell_t mem [DEPTH];

  // only the owning port writes this bank; masked merge of the lane
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wr_idx] <= (mem[wr_idx] & ~wr_mask) | (wr_val & wr_mask);
    end
  end

  assign rd_q0 = mem[rd_idx0];
  assign rd_q1 = mem[rd_idx1];

endmodule

// File: rtl/adpr_port.sv
module adpr_port
  import adpr_pkg::*;
#(
  parameter  int unsigned WIDTH  = 36,
  parameter  int unsigned DEPTH  = 512,
  parameter  cell_t       INIT   = '0,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IDX_W + LANE_LOG2W
) (
  input  logic               clk,
  input  logic               en,
  input  logic               we,
  input  logic               srst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_DW-1:0] wdata,
  input  logic [WORD_PW-1:0] wpar,
  input  cell_t              rd_word,
  output logic [IDX_W-1:0]   word_idx,
  output logic               wr_fire,
  output cell_t              wr_mask,
  output cell_t              wr_bits,
  output logic [WORD_DW-1:0] rdata,
  output logic [WORD_PW-1:0] rpar
);

  localparam int unsigned          LL       = lane_log2(WIDTH);
  localparam int unsigned          DB       = data_bits(WIDTH);
  localparam int unsigned          PB       = par_bits(WIDTH);
  localparam cell_t                LOW_MASK = lane_mask(WIDTH, 0);
  localparam logic [LANE_LOG2W-1:0] LANE_SEL = LANE_LOG2W'((1 << LL) - 1);

  logic [LANE_LOG2W-1:0] lane;
  cell_t                 in_low;
  cell_t                 rd_low;
  cell_t                 out_d;
  cell_t                 out_q;
  logic                  armed_q = 1'b0;

  always_comb begin
    lane     = addr[LANE_LOG2W-1:0] & LANE_SEL;
    word_idx = IDX_W'(addr >> LL);
    in_low   = cell_t'({wpar, wdata}) & LOW_MASK;
    wr_fire  = en & we;
    wr_mask  = lane_mask(WIDTH, int'(lane));
    wr_bits  = lane_put(WIDTH, int'(lane), in_low);
    rd_low   = lane_take(WIDTH, int'(lane), rd_word);
    if (srst)    out_d = INIT & LOW_MASK;
    else if (we) out_d = in_low;
    else         out_d = rd_low;
  end

  always_ff @(posedge clk) begin
    if (en) out_q <= out_d;
  end

  always_ff @(posedge clk) armed_q <= 1'b1;

  assign rdata = out_q.dat;
  assign rpar  = out_q.par;

  always_comb begin
    if (wr_fire) begin
      AST_LANE_WIDTH: assert ($countones(wr_mask) == DB + PB); // R1
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!armed_q) !en |=> $stable(out_q)); // R5
  AST_SRST_INIT: assert property (@(posedge clk) disable iff (!armed_q) (en && srst) |=> (out_q == (INIT & LOW_MASK))); // R8
  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!armed_q) (en && we && !srst) |=> (out_q == ($past({wpar, wdata}) & LOW_MASK))); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!armed_q) en |=> ((out_q & ~LOW_MASK) == '0)); // R4

  if (PB == 0) begin : g_no_par
    AST_NARROW_NO_PAR: assert property (@(posedge clk) disable iff (!armed_q) en |=> (rpar == '0)); // R3
    always_comb begin
      if (wr_fire) begin
        AST_NARROW_PAR_SAFE: assert (wr_mask.par == '0); // R3
      end
    end
  end

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import adpr_pkg::*;
#(
  parameter int unsigned A_WIDTH = 36,
  parameter int unsigned B_WIDTH = 9,
  parameter logic [35:0] A_INIT  = '0,
  parameter logic [35:0] B_INIT  = '0,
  parameter int unsigned DEPTH   = 512,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IDX_W + LANE_LOG2W
) (
  input  logic               a_clk,
  input  logic               a_en,
  input  logic               a_we,
  input  logic               a_srst,
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [WORD_DW-1:0] a_wdata,
  input  logic [WORD_PW-1:0] a_wpar,
  output logic [WORD_DW-1:0] a_rdata,
  output logic [WORD_PW-1:0] a_rpar,
  input  logic               b_clk,
  input  logic               b_en,
  input  logic               b_we,
  input  logic               b_srst,
  input  logic [ADDR_W-1:0]  b_addr,
  input  logic [WORD_DW-1:0] b_wdata,
  input  logic [WORD_PW-1:0] b_wpar,
  output logic [WORD_DW-1:0] b_rdata,
  output logic [WORD_PW-1:0] b_rpar
);

  localparam int unsigned PORT_W    [2] = '{A_WIDTH, B_WIDTH};
  localparam cell_t       PORT_INIT [2] = '{cell_t'(A_INIT), cell_t'(B_INIT)};

  logic               p_clk   [2];
  logic               p_en    [2];
  logic               p_we    [2];
  logic               p_srst  [2];
  logic [ADDR_W-1:0]  p_addr  [2];
  logic [WORD_DW-1:0] p_wdata [2];
  logic [WORD_PW-1:0] p_wpar  [2];
  logic [WORD_DW-1:0] p_rdata [2];
  logic [WORD_PW-1:0] p_rpar  [2];

  logic [IDX_W-1:0]   idx      [2];
  logic               fire     [2];
  cell_t              wmask    [2];
  cell_t              wbits    [2];
  cell_t              bank_val [2];
  cell_t              merged   [2];
  cell_t              other_at [2];
  cell_t              q_at0    [2];  // bank g read at port A index
  cell_t              q_at1    [2];  // bank g read at port B index

  assign p_clk[0]   = a_clk;   assign p_clk[1]   = b_clk;
  assign p_en[0]    = a_en;    assign p_en[1]    = b_en;
  assign p_we[0]    = a_we;    assign p_we[1]    = b_we;
  assign p_srst[0]  = a_srst;  assign p_srst[1]  = b_srst;
  assign p_addr[0]  = a_addr;  assign p_addr[1]  = b_addr;
  assign p_wdata[0] = a_wdata; assign p_wdata[1] = b_wdata;
  assign p_wpar[0]  = a_wpar;  assign p_wpar[1]  = b_wpar;
  assign a_rdata    = p_rdata[0];
  assign a_rpar     = p_rpar[0];
  assign b_rdata    = p_rdata[1];
  assign b_rpar     = p_rpar[1];

  for (genvar g = 0; g < 2; g++) begin : g_side
    if (g == 0) begin : g_view
      assign merged[g]   = q_at0[0] ^ q_at0[1];
      assign other_at[g] = q_at0[1];
    end else begin : g_view
      assign merged[g]   = q_at1[0] ^ q_at1[1];
      assign other_at[g] = q_at1[0];
    end

    // stored value is the XOR of both banks, so a write pre-cancels the other bank
    assign bank_val[g] = wbits[g] ^ other_at[g];

    adpr_port #(
      .WIDTH (PORT_W[g]),
      .DEPTH (DEPTH),
      .INIT  (PORT_INIT[g])
    ) u_port (
      .clk      (p_clk[g]),
      .en       (p_en[g]),
      .we       (p_we[g]),
      .srst     (p_srst[g]),
      .addr     (p_addr[g]),
      .wdata    (p_wdata[g]),
      .wpar     (p_wpar[g]),
      .rd_word  (merged[g]),
      .word_idx (idx[g]),
      .wr_fire  (fire[g]),
      .wr_mask  (wmask[g]),
      .wr_bits  (wbits[g]),
      .rdata    (p_rdata[g]),
      .rpar     (p_rpar[g])
    );

    adpr_bank #(
      .DEPTH (DEPTH)
    ) u_bank (
      .clk     (p_clk[g]),
      .we      (fire[g]),
      .wr_idx  (idx[g]),
      .wr_mask (wmask[g]),
      .wr_val  (bank_val[g]),
      .rd_idx0 (idx[0]),
      .rd_idx1 (idx[1]),
      .rd_q0   (q_at0[g]),
      .rd_q1   (q_at1[g])
    );
  end

endmodule

// File: tb/asym_dpram_tb.sv
module asym_dpram_tb;

  localparam int unsigned NDUT = 6;
  localparam int unsigned BW [NDUT] = '{1, 2, 4, 9, 18, 36};
  localparam logic [35:0] A_INIT = 36'hA_5A5A_C3C3;
  localparam logic [35:0] B_INIT = 36'h6_F0F0_9669;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        a_en = 0, a_we = 0, a_srst = 0;
  logic [13:0] a_addr = '0;
  logic [31:0] a_wd = '0;
  logic [3:0]  a_wp = '0;
  logic        b_en = 0, b_we = 0, b_srst = 0;
  logic [13:0] b_addr = '0;
  logic [31:0] b_wd = '0;
  logic [3:0]  b_wp = '0;

  logic [31:0] a_rd [NDUT];
  logic [3:0]  a_rp [NDUT];
  logic [31:0] b_rd [NDUT];
  logic [3:0]  b_rp [NDUT];

  for (genvar k = 0; k < NDUT; k++) begin : g_dut
    asym_dpram #(
      .A_WIDTH (36),
      .B_WIDTH (BW[k]),
      .A_INIT  (A_INIT),
      .B_INIT  (B_INIT)
    ) u_dut (
      .a_clk (clk), .a_en (a_en), .a_we (a_we), .a_srst (a_srst),
      .a_addr (a_addr), .a_wdata (a_wd), .a_wpar (a_wp),
      .a_rdata (a_rd[k]), .a_rpar (a_rp[k]),
      .b_clk (clk), .b_en (b_en), .b_we (b_we), .b_srst (b_srst),
      .b_addr (b_addr), .b_wdata (b_wd), .b_wpar (b_wp),
      .b_rdata (b_rd[k]), .b_rpar (b_rp[k])
    );
  end

  int          n_checks = 0;
  int          n_errors = 0;
  logic [31:0] ref_d [NDUT][512];
  logic [3:0]  ref_p [NDUT][512];

  // bench view of the shapes: data bits, parity bits, lanes per word
  function automatic int unsigned m_db(input int unsigned w);
    return (w >= 9) ? w - w / 9 : w;
  endfunction
  function automatic int unsigned m_pb(input int unsigned w);
    return (w >= 9) ? w / 9 : 0;
  endfunction
  function automatic int unsigned m_units(input int unsigned w);
    return 32 / m_db(w);
  endfunction

  function automatic logic [31:0] mix(input int unsigned i);
    return (32'h9E37_79B9 * (i + 1)) ^ (i << 11) ^ 32'h1234_0F0F;
  endfunction

  // keep only what a shape can carry, as {par, data}
  function automatic logic [35:0] shape_cut(input int unsigned w, input logic [35:0] v);
    logic [35:0] r = '0;
    for (int j = 0; j < 32; j++) if (j < m_db(w)) r[j] = v[j];
    for (int j = 0; j < 4; j++)  if (j < m_pb(w)) r[32+j] = v[32+j];
    return r;
  endfunction

  task automatic model_wr(input int k, input int unsigned w, input int unsigned addr,
                          input logic [31:0] d, input logic [3:0] p);
    int unsigned u = m_units(w);
    int unsigned word = (addr / u) % 512;
    int unsigned lane = addr % u;
    for (int j = 0; j < 32; j++) if (j < m_db(w)) ref_d[k][word][lane*m_db(w)+j] = d[j];
    for (int j = 0; j < 4; j++)  if (j < m_pb(w)) ref_p[k][word][lane*m_pb(w)+j] = p[j];
  endtask

  function automatic logic [35:0] model_rd(input int k, input int unsigned w, input int unsigned addr);
    logic [35:0] r = '0;
    int unsigned u = m_units(w);
    int unsigned word = (addr / u) % 512;
    int unsigned lane = addr % u;
    for (int j = 0; j < 32; j++) if (j < m_db(w)) r[j] = ref_d[k][word][lane*m_db(w)+j];
    for (int j = 0; j < 4; j++)  if (j < m_pb(w)) r[32+j] = ref_p[k][word][lane*m_pb(w)+j];
    return r;
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    a_en = 1; a_srst = 1; b_en = 1; b_srst = 1; a_we = 0; b_we = 0;
    step();
    for (int k = 0; k < NDUT; k++) begin
      check("R8 reset A", {a_rp[k], a_rd[k]}, A_INIT);
      check("R8 reset B", {b_rp[k], b_rd[k]}, shape_cut(BW[k], B_INIT));
    end
    a_srst = 0; b_srst = 0; a_en = 0; b_en = 0;
  endtask

  task automatic t_fill_wide();
    a_en = 1; a_we = 1;
    for (int i = 0; i < 512; i++) begin
      a_addr = 14'(i); a_wd = mix(i); a_wp = 4'(i) ^ 4'h9;
      step();
      check("R7 write-first A", {a_rp[0], a_rd[0]}, {a_wp, a_wd});
      for (int k = 0; k < NDUT; k++) model_wr(k, 36, i, a_wd, a_wp);
    end
    a_we = 0; a_en = 0;
  endtask

  task automatic t_cross_read();
    b_en = 1; b_we = 0;
    for (int i = 0; i < 16384; i++) begin
      b_addr = 14'(i);
      step();
      for (int k = 0; k < NDUT; k++)
        check("R9 R1 R2 R4 narrow read", {b_rp[k], b_rd[k]}, model_rd(k, BW[k], i));
    end
    b_en = 0;
  endtask

  task automatic t_narrow_write();
    b_en = 1; b_we = 1; b_wp = 4'hF;
    for (int i = 0; i < 1024; i++) begin
      b_addr = 14'(i); b_wd = ~mix(i + 77);
      step();
      for (int k = 0; k < NDUT; k++) begin
        check("R7 write-first B", {b_rp[k], b_rd[k]}, shape_cut(BW[k], {b_wp, b_wd}));
        model_wr(k, BW[k], i, b_wd, b_wp);
      end
    end
    b_we = 0; b_en = 0;
    a_en = 1;
    for (int i = 0; i < 512; i++) begin
      a_addr = 14'(i);
      step();
      for (int k = 0; k < NDUT; k++)
        check("R3 R9 wide readback", {a_rp[k], a_rd[k]}, model_rd(k, 36, i));
    end
    a_en = 0;
  endtask

  task automatic t_en_low();
    logic [35:0] held_a [NDUT];
    logic [35:0] held_b [NDUT];
    a_en = 1; a_addr = 14'd5; b_en = 1; b_addr = 14'd3;
    step();
    for (int k = 0; k < NDUT; k++) begin
      held_a[k] = model_rd(k, 36, 5);
      held_b[k] = model_rd(k, BW[k], 3);
    end
    a_en = 0; a_we = 1; a_wd = 32'hDEAD_BEEF; a_wp = 4'hF; a_addr = 14'd6;
    b_en = 0; b_we = 1; b_wd = 32'h0000_0000; b_wp = 4'h0; b_addr = 14'd2;
    step();
    step();
    for (int k = 0; k < NDUT; k++) begin
      check("R5 hold A", {a_rp[k], a_rd[k]}, held_a[k]);
      check("R5 hold B", {b_rp[k], b_rd[k]}, held_b[k]);
    end
    a_we = 0; b_we = 0; a_en = 1; b_en = 1;
    step();
    for (int k = 0; k < NDUT; k++) begin
      check("R5 no write A", {a_rp[k], a_rd[k]}, model_rd(k, 36, 6));
      check("R5 no write B", {b_rp[k], b_rd[k]}, model_rd(k, BW[k], 2));
    end
    a_en = 0; b_en = 0;
  endtask

  task automatic t_registered();
    a_en = 1; a_addr = 14'd20;
    step();
    a_addr = 14'd21;
    #1;
    for (int k = 0; k < NDUT; k++)
      check("R6 before edge", {a_rp[k], a_rd[k]}, model_rd(k, 36, 20));
    step();
    for (int k = 0; k < NDUT; k++)
      check("R6 after edge", {a_rp[k], a_rd[k]}, model_rd(k, 36, 21));
    a_en = 0;
  endtask

  task automatic t_srst_write();
    a_en = 1; a_we = 1; a_srst = 1; a_addr = 14'd9; a_wd = 32'h0BAD_F00D; a_wp = 4'h6;
    step();
    for (int k = 0; k < NDUT; k++) begin
      check("R8 srst over write", {a_rp[k], a_rd[k]}, A_INIT);
      model_wr(k, 36, 9, a_wd, a_wp);
    end
    a_we = 0; a_srst = 0;
    b_en = 1; b_srst = 1; b_addr = 14'd0;
    step();
    for (int k = 0; k < NDUT; k++) begin
      check("R8 write kept", {a_rp[k], a_rd[k]}, model_rd(k, 36, 9));
      check("R8 srst B", {b_rp[k], b_rd[k]}, shape_cut(BW[k], B_INIT));
    end
    b_srst = 0;
    step();
    for (int k = 0; k < NDUT; k++)
      check("R8 array kept", {b_rp[k], b_rd[k]}, model_rd(k, BW[k], 0));
    a_en = 0; b_en = 0;
  endtask

  task automatic t_dual_write();
    a_en = 1; a_we = 1; a_addr = 14'd100; a_wd = 32'h55AA_33CC; a_wp = 4'h3;
    b_en = 1; b_we = 1; b_addr = 14'd0;   b_wd = 32'hC001_D00D; b_wp = 4'hA;
    step();
    for (int k = 0; k < NDUT; k++) begin
      model_wr(k, 36, 100, a_wd, a_wp);
      model_wr(k, BW[k], 0, b_wd, b_wp);
    end
    a_we = 0; b_we = 0;
    step();
    for (int k = 0; k < NDUT; k++) begin
      check("R10 port A word", {a_rp[k], a_rd[k]}, model_rd(k, 36, 100));
      check("R10 port B lane", {b_rp[k], b_rd[k]}, model_rd(k, BW[k], 0));
    end
    a_addr = 14'd0;
    step();
    for (int k = 0; k < NDUT; k++)
      check("R10 R9 B seen on A", {a_rp[k], a_rd[k]}, model_rd(k, 36, 0));
    a_en = 0; b_en = 0;
  endtask

  task automatic run_all();
    step();
    t_reset();
    t_fill_wide();
    t_cross_read();
    t_narrow_write();
    t_en_low();
    t_registered();
    t_srst_write();
    t_dual_write();
  endtask

  initial begin
    bit timed_out = 0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule